// File: doc/BRIEF.md
# Protected User-Level Message Port

This block sits between a processor and a packet network. It lets unprivileged code send and receive messages without trapping to the kernel, while the block itself enforces the privilege boundary. There are three logical networks: two data networks (codes 0 and 1) and one control network (code 2). Each network has its own outbound queue and its own inbound queue. A send names a network, a tag, a user/system envelope bit and a payload. A small tag-indexed table, written by privileged software, gives two things per tag: the route that is stamped into the outgoing envelope, and whether unprivileged code may use that tag.

The outbound queues share one physical transmit port. An arbiter serves the control network first and alternates between the two data networks. On the receive side, every arriving message is accepted. A user message lands in the inbound queue of its network, where the processor reads it directly. A system message goes to a separate system queue and holds the interrupt line high until that queue is drained. Sticky error bits record protection violations and messages dropped because a queue was full.

Top module: `unet_port`

## Requirements
- R1: After reset, all outbound, inbound and system queues are empty, `tx_valid`, `irq` and the three error bits are 0, and every table entry holds route 0 with user access denied.
- R2: A `tbl_we` pulse stores `tbl_route` and `tbl_user` in entry `tbl_addr`. An accepted send with tag t carries the route held in entry t at the time of the send on `tx_route`.
- R3: A send with `snd_priv`=0 is refused if `snd_sys`=1 or if its tag's entry has user access 0. A refused send is not queued and sets the sticky `prot_err`. A send with `snd_priv`=1 is never refused for protection.
- R4: An outbound queue holds DEPTH messages. A permitted send to a full queue is dropped, sets the sticky `snd_ovf`, and leaves the queued messages unchanged.
- R5: Bit n of `out_full`, `out_empty`, `in_full` and `in_empty` reports network n (0 and 1 are data, 2 is control). A send or receive naming network 3 changes no queue and no error bit.
- R6: Each outbound queue delivers its messages in write order. Each message carries the sender's system bit, tag, translated route and data, together with its network code on `tx_net`.
- R7: While no offer is held, a non-empty control queue wins the transmit port. When both data queues wait, they alternate, with network 0 served first after reset.
- R8: A message offered with `tx_ready`=0 stays on the transmit outputs unchanged until `tx_ready`=1 takes it, even if the control queue fills meanwhile.
- R9: A received message with `rx_sys`=0 enters the inbound queue of `rx_net` and does not raise `irq`. `usr_tag`/`usr_data` show the head of the queue selected by `usr_net`, and `usr_rd` removes it, in arrival order.
- R10: A received message with `rx_sys`=1 enters the system queue with its network, tag and data. `irq` is high from the next cycle until the last system message has been removed with `sys_rd`.
- R11: A received message whose destination queue (inbound or system, depth SDEPTH) is full is dropped and sets the sticky `rx_ovf`. The queue's contents are unchanged.
- R12: `err_clr` clears all three error bits. If an error occurs in the same cycle as `err_clr`, that error bit is set.
- R13: A `usr_rd` or `sys_rd` on an empty queue has no effect on the queue's later contents or status.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| err_clr | input | 1 | Clear the sticky error bits |
| tbl_we | input | 1 | Write one table entry |
| tbl_addr | input | TW | Entry to write |
| tbl_route | input | RW | Route for the entry |
| tbl_user | input | 1 | 1 lets unprivileged senders use the tag |
| snd_valid | input | 1 | Send request this cycle |
| snd_net | input | 2 | Target network |
| snd_priv | input | 1 | Sender runs privileged |
| snd_sys | input | 1 | Envelope system bit |
| snd_tag | input | TW | Message tag |
| snd_data | input | DW | Payload |
| out_full | output | 3 | Outbound queue full, per network |
| out_empty | output | 3 | Outbound queue empty, per network |
| tx_valid | output | 1 | Message offered to the network |
| tx_ready | input | 1 | Network takes the offered message |
| tx_net | output | 2 | Network of the offered message |
| tx_sys | output | 1 | System bit of the offered message |
| tx_tag | output | TW | Tag of the offered message |
| tx_route | output | RW | Translated route |
| tx_data | output | DW | Payload |
| rx_valid | input | 1 | Message arriving |
| rx_net | input | 2 | Network it arrived on |
| rx_sys | input | 1 | Its system bit |
| rx_tag | input | TW | Its tag |
| rx_data | input | DW | Its payload |
| usr_rd | input | 1 | Remove head of the selected inbound queue |
| usr_net | input | 2 | Inbound queue selected for reading |
| usr_tag | output | TW | Tag at that head |
| usr_data | output | DW | Payload at that head |
| in_full | output | 3 | Inbound queue full, per network |
| in_empty | output | 3 | Inbound queue empty, per network |
| sys_rd | input | 1 | Remove head of the system queue |
| sys_net | output | 2 | Network of the system head |
| sys_tag | output | TW | Tag of the system head |
| sys_data | output | DW | Payload of the system head |
| sys_empty | output | 1 | System queue empty |
| sys_full | output | 1 | System queue full |
| irq | output | 1 | System message pending |
| prot_err | output | 1 | Sticky protection violation |
| snd_ovf | output | 1 | Sticky outbound drop |
| rx_ovf | output | 1 | Sticky inbound drop |

## Verification
The properties assume that every input is at a known level once reset is released. They also assume that the network code 3 appears only as the ignored code, so the checks that index a per-network status bit are guarded against it. The hold and priority properties further assume that `tx_ready` is driven only from the testbench and never depends on `tx_valid` in the same cycle. The stimulus drives every input one time unit after the rising edge. It leaves all inputs at 0 between operations and never issues a send with network 3 and a status lookup together, so these assumptions hold throughout.

// File: rtl/unet_port.sv
module unet_port #(
  parameter int DW     = 8,
  parameter int TW     = 2,
  parameter int RW     = 4,
  parameter int DEPTH  = 4,
  parameter int SDEPTH = 4
)(
  input  logic          clk,
  input  logic          rst_n,
  input  logic          err_clr,
  input  logic          tbl_we,
  input  logic [TW-1:0] tbl_addr,
  input  logic [RW-1:0] tbl_route,
  input  logic          tbl_user,
  input  logic          snd_valid,
  input  logic [1:0]    snd_net,
  input  logic          snd_priv,
  input  logic          snd_sys,
  input  logic [TW-1:0] snd_tag,
  input  logic [DW-1:0] snd_data,
  output logic [2:0]    out_full,
  output logic [2:0]    out_empty,
  output logic          tx_valid,
  input  logic          tx_ready,
  output logic [1:0]    tx_net,
  output logic          tx_sys,
  output logic [TW-1:0] tx_tag,
  output logic [RW-1:0] tx_route,
  output logic [DW-1:0] tx_data,
  input  logic          rx_valid,
  input  logic [1:0]    rx_net,
  input  logic          rx_sys,
  input  logic [TW-1:0] rx_tag,
  input  logic [DW-1:0] rx_data,
  input  logic          usr_rd,
  input  logic [1:0]    usr_net,
  output logic [TW-1:0] usr_tag,
  output logic [DW-1:0] usr_data,
  output logic [2:0]    in_full,
  output logic [2:0]    in_empty,
  input  logic          sys_rd,
  output logic [1:0]    sys_net,
  output logic [TW-1:0] sys_tag,
  output logic [DW-1:0] sys_data,
  output logic          sys_empty,
  output logic          sys_full,
  output logic          irq,
  output logic          prot_err,
  output logic          snd_ovf,
  output logic          rx_ovf
);
  localparam int NT  = 1 << TW;
  localparam int AW  = $clog2(DEPTH);
  localparam int SAW = $clog2(SDEPTH);
  localparam int OEW = 1 + TW + RW + DW;
  localparam int IEW = TW + DW;
  localparam int SEW = 2 + TW + DW;

  logic [RW-1:0] route_t [NT];
  logic [NT-1:0] user_t;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      user_t <= '0;
      for (int i = 0; i < NT; i++) route_t[i] <= '0;
    end else if (tbl_we) begin
      route_t[tbl_addr] <= tbl_route;
      user_t[tbl_addr]  <= tbl_user;
    end

  logic snd_live, rx_live, viol, snd_go;
  assign snd_live = snd_valid && snd_net != 2'd3;
  assign rx_live  = rx_valid && rx_net != 2'd3;
  assign viol     = !snd_priv && (snd_sys || !user_t[snd_tag]);
  assign snd_go   = snd_live && !viol;

  logic [2:0] owr, opop, iwr, ird;
  logic [3:0] ofx, ifx;
  logic [OEW-1:0] ohead [4];
  logic [IEW-1:0] ihead [4];
  assign ofx = {1'b0, out_full};
  assign ifx = {1'b0, in_full};
  assign ohead[3] = '0;
  assign ihead[3] = '0;

  for (genvar n = 0; n < 3; n++) begin : g_net
    logic [OEW-1:0] omem [DEPTH];
    logic [IEW-1:0] imem [DEPTH];
    logic [AW-1:0]  owp, orp, iwp, irp;
    logic [AW:0]    ocnt, icnt;

    assign out_full[n]  = ocnt == (AW+1)'(DEPTH);
    assign out_empty[n] = ocnt == '0;
    assign in_full[n]   = icnt == (AW+1)'(DEPTH);
    assign in_empty[n]  = icnt == '0;

    assign owr[n]  = snd_go && snd_net == 2'(n) && !out_full[n];
    assign opop[n] = tx_valid && tx_ready && tx_net == 2'(n);
    assign iwr[n]  = rx_live && !rx_sys && rx_net == 2'(n) && !in_full[n];
    assign ird[n]  = usr_rd && usr_net == 2'(n) && !in_empty[n];

    assign ohead[n] = omem[orp];
    assign ihead[n] = imem[irp];

    always_ff @(posedge clk) begin
      if (owr[n]) omem[owp] <= {snd_sys, snd_tag, route_t[snd_tag], snd_data};
      if (iwr[n]) imem[iwp] <= {rx_tag, rx_data};
    end

    always_ff @(posedge clk or negedge rst_n)
      if (!rst_n) begin
        owp <= '0; orp <= '0; ocnt <= '0;
        iwp <= '0; irp <= '0; icnt <= '0;
      end else begin
        if (owr[n])  owp <= owp + 1'b1;
        if (opop[n]) orp <= orp + 1'b1;
        ocnt <= ocnt + (AW+1)'(owr[n]) - (AW+1)'(opop[n]);
        if (iwr[n])  iwp <= iwp + 1'b1;
        if (ird[n])  irp <= irp + 1'b1;
        icnt <= icnt + (AW+1)'(iwr[n]) - (AW+1)'(ird[n]);
      end
  end

  logic [SEW-1:0] smem [SDEPTH];
  logic [SAW-1:0] swp, srp;
  logic [SAW:0]   scnt;
  logic swr, srd;

  assign sys_full  = scnt == (SAW+1)'(SDEPTH);
  assign sys_empty = scnt == '0;
  assign irq       = !sys_empty;
  assign swr = rx_live && rx_sys && !sys_full;
  assign srd = sys_rd && !sys_empty;
  assign {sys_net, sys_tag, sys_data} = smem[srp];

  always_ff @(posedge clk)
    if (swr) smem[swp] <= {rx_net, rx_tag, rx_data};

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      swp <= '0; srp <= '0; scnt <= '0;
    end else begin
      if (swr) swp <= swp + 1'b1;
      if (srd) srp <= srp + 1'b1;
      scnt <= scnt + (SAW+1)'(swr) - (SAW+1)'(srd);
    end

  assign usr_tag  = ihead[usr_net][IEW-1 -: TW];
  assign usr_data = ihead[usr_net][DW-1:0];

  logic [2:0] req;
  logic       pick1, hold_q;
  logic [1:0] hold_net, arb_net;
  assign req      = ~out_empty;
  assign tx_valid = |req;

  always_comb begin
    arb_net = 2'd0;
    if (req[2])                arb_net = 2'd2;
    else if (req[0] && req[1]) arb_net = pick1 ? 2'd1 : 2'd0;
    else if (req[1])           arb_net = 2'd1;
  end

  assign tx_net = hold_q ? hold_net : arb_net;
  assign {tx_sys, tx_tag, tx_route, tx_data} = ohead[tx_net];

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      pick1 <= 1'b0; hold_q <= 1'b0; hold_net <= 2'd0;
    end else begin
      hold_q   <= tx_valid && !tx_ready;
      hold_net <= tx_net;
      if (tx_valid && tx_ready && tx_net != 2'd2) pick1 <= tx_net == 2'd0;
    end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      prot_err <= 1'b0; snd_ovf <= 1'b0; rx_ovf <= 1'b0;
    end else begin
      if (err_clr) begin
        prot_err <= 1'b0; snd_ovf <= 1'b0; rx_ovf <= 1'b0;
      end
      if (snd_live && viol) prot_err <= 1'b1;
      if (snd_go && ofx[snd_net]) snd_ovf <= 1'b1;
      if (rx_live && (rx_sys ? sys_full : ifx[rx_net])) rx_ovf <= 1'b1;
    end
endmodule

// File: rtl/unet_port_chk.sv
module unet_port_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       err_clr,
  input logic       snd_valid,
  input logic [1:0] snd_net,
  input logic       snd_priv,
  input logic       snd_sys,
  input logic [2:0] out_full,
  input logic [2:0] out_empty,
  input logic       tx_valid,
  input logic       tx_ready,
  input logic [1:0] tx_net,
  input logic       tx_sys,
  input logic       rx_valid,
  input logic [1:0] rx_net,
  input logic       rx_sys,
  input logic       sys_full,
  input logic       sys_empty,
  input logic       irq,
  input logic       prot_err,
  input logic       snd_ovf,
  input logic       rx_ovf
);
  logic [3:0] ofull4;
  assign ofull4 = {1'b0, out_full};

  a_r3_sys_flag_refused: assert property (@(posedge clk) disable iff (!rst_n)
    snd_valid && snd_net != 2'd3 && !snd_priv && snd_sys |=> prot_err);

  a_r4_full_drop_flag: assert property (@(posedge clk) disable iff (!rst_n)
    snd_valid && snd_net != 2'd3 && snd_priv && ofull4[snd_net] |=> snd_ovf);

  for (genvar k = 0; k < 3; k++) begin : g_full
    a_r4_no_overwrite: assert property (@(posedge clk) disable iff (!rst_n)
      out_full[k] && !(tx_valid && tx_ready && tx_net == 2'(k)) |=> out_full[k]);
  end

  a_r7_control_first: assert property (@(posedge clk) disable iff (!rst_n)
    tx_valid && !out_empty[2] && !$past(tx_valid && !tx_ready) |-> tx_net == 2'd2);

  a_r8_offer_held: assert property (@(posedge clk) disable iff (!rst_n)
    tx_valid && !tx_ready |=> tx_valid && $stable(tx_net) && $stable(tx_sys));

  a_r9_user_no_irq: assert property (@(posedge clk) disable iff (!rst_n)
    sys_empty && !(rx_valid && rx_sys) |=> !irq);

  a_r10_sys_irq: assert property (@(posedge clk) disable iff (!rst_n)
    rx_valid && rx_sys && rx_net != 2'd3 && !sys_full |=> irq);

  a_r12_clear: assert property (@(posedge clk) disable iff (!rst_n)
    err_clr && !snd_valid && !rx_valid |=> !prot_err && !snd_ovf && !rx_ovf);
endmodule

bind unet_port unet_port_chk u_chk (.*);

// File: tb/sim_unet_port.sv
`timescale 1ns/1ps
module sim_unet_port;
  localparam int DW = 8, TW = 2, RW = 4, DEPTH = 4, SDEPTH = 4;

  logic clk = 0, rst_n = 0, err_clr = 0;
  logic tbl_we = 0, tbl_user = 0;
  logic [TW-1:0] tbl_addr = 0;
  logic [RW-1:0] tbl_route = 0;
  logic snd_valid = 0, snd_priv = 0, snd_sys = 0;
  logic [1:0] snd_net = 0;
  logic [TW-1:0] snd_tag = 0;
  logic [DW-1:0] snd_data = 0;
  logic [2:0] out_full, out_empty, in_full, in_empty;
  logic tx_valid, tx_ready = 0, tx_sys;
  logic [1:0] tx_net;
  logic [TW-1:0] tx_tag;
  logic [RW-1:0] tx_route;
  logic [DW-1:0] tx_data;
  logic rx_valid = 0, rx_sys = 0;
  logic [1:0] rx_net = 0;
  logic [TW-1:0] rx_tag = 0;
  logic [DW-1:0] rx_data = 0;
  logic usr_rd = 0, sys_rd = 0;
  logic [1:0] usr_net = 0, sys_net;
  logic [TW-1:0] usr_tag, sys_tag;
  logic [DW-1:0] usr_data, sys_data;
  logic sys_empty, sys_full, irq, prot_err, snd_ovf, rx_ovf;

  int checks = 0, errors = 0;
  bit done = 0;

  unet_port #(.DW(DW), .TW(TW), .RW(RW), .DEPTH(DEPTH), .SDEPTH(SDEPTH)) u0 (.*);

  always #2.5 clk = ~clk;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic tick;
    @(posedge clk); #1;
  endtask

  task automatic snd(input logic [1:0] n, input logic p, input logic s,
                     input logic [TW-1:0] t, input logic [DW-1:0] d);
    snd_valid = 1; snd_net = n; snd_priv = p; snd_sys = s; snd_tag = t; snd_data = d;
    tick; snd_valid = 0;
  endtask

  task automatic rx(input logic [1:0] n, input logic s,
                    input logic [TW-1:0] t, input logic [DW-1:0] d);
    rx_valid = 1; rx_net = n; rx_sys = s; rx_tag = t; rx_data = d;
    tick; rx_valid = 0;
  endtask

  task automatic pop_tx;  tx_ready = 1; tick; tx_ready = 0; endtask
  task automatic pop_usr; usr_rd = 1; tick; usr_rd = 0; endtask
  task automatic pop_sys; sys_rd = 1; tick; sys_rd = 0; endtask
  task automatic clr;     err_clr = 1; tick; err_clr = 0; endtask

  function automatic logic [RW-1:0] rt(input int t);
    return RW'((t * 5 + 3) % 16);
  endfunction

  initial begin
    #(5.0 * 190000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) tick;
    rst_n = 1;
    tick;
    // R1 reset state
    chk("R1 out_empty", out_empty, 3'b111);
    chk("R1 in_empty", in_empty, 3'b111);
    chk("R1 sys_empty", sys_empty, 1);
    chk("R1 irq", irq, 0);
    chk("R1 tx_valid", tx_valid, 0);
    chk("R1 errors", {prot_err, snd_ovf, rx_ovf}, 0);
    snd(0, 1, 0, 1, 8'h11);
    chk("R1 reset route", tx_route, 0);
    pop_tx;
    snd(0, 0, 0, 0, 8'h12);
    chk("R1 reset user denied", {prot_err, out_empty[0]}, 2'b11);
    clr;

    // R2 table programming: tag 3 is system-only
    for (int t = 0; t < 4; t++) begin
      tbl_we = 1; tbl_addr = TW'(t); tbl_route = rt(t); tbl_user = (t != 3);
      tick;
    end
    tbl_we = 0;

    // R3 sweep over privilege, flag and tag
    for (int p = 0; p < 2; p++)
      for (int s = 0; s < 2; s++)
        for (int t = 0; t < 4; t++) begin
          logic ok;
          ok = (p == 1) || (s == 0 && t != 3);
          snd(0, p[0], s[0], TW'(t), DW'(p * 64 + s * 16 + t));
          chk("R3 queued", out_empty[0], !ok);
          chk("R3 prot_err", prot_err, !ok);
          if (ok) begin
            chk("R2 route", tx_route, rt(t));
            chk("R6 fields", {tx_net, tx_sys, tx_tag, tx_data},
                {2'd0, s[0], TW'(t), DW'(p * 64 + s * 16 + t)});
            pop_tx;
          end
          clr;
        end

    // R5 network code 3 ignored
    snd(3, 1, 0, 0, 8'h33);
    rx(3, 0, 0, 8'h34);
    rx(3, 1, 0, 8'h35);
    chk("R5 net3 queues", {out_empty, in_empty, sys_empty}, 7'h7f);
    chk("R5 net3 errors", {prot_err, snd_ovf, rx_ovf, tx_valid}, 0);

    // R4 outbound overflow on network 1, R6 order
    for (int i = 0; i < DEPTH; i++) snd(1, 1, 0, 0, DW'(8'h10 + i));
    chk("R5 out_full bit", out_full, 3'b010);
    chk("R5 out_empty bit", out_empty, 3'b101);
    snd(1, 1, 0, 0, 8'hEE);
    chk("R4 snd_ovf", snd_ovf, 1);
    for (int i = 0; i < DEPTH; i++) begin
      chk("R6 order", {tx_net, tx_data}, {2'd1, DW'(8'h10 + i)});
      pop_tx;
    end
    chk("R4 drop not stored", out_empty, 3'b111);
    clr;

    // R7 arbitration, R8 hold
    begin
      logic [1:0] en [5] = '{2'd0, 2'd2, 2'd1, 2'd0, 2'd1};
      logic [7:0] ed [5] = '{8'hA0, 8'hC0, 8'hB0, 8'hA1, 8'hB1};
      snd(0, 1, 0, 0, 8'hA0);
      snd(0, 1, 0, 0, 8'hA1);
      snd(1, 1, 0, 0, 8'hB0);
      snd(1, 1, 0, 0, 8'hB1);
      snd(2, 1, 0, 0, 8'hC0);
      tick;
      chk("R8 held offer", {tx_net, tx_data}, {2'd0, 8'hA0});
      for (int i = 0; i < 5; i++) begin
        chk("R7 grant order", {tx_net, tx_data}, {en[i], ed[i]});
        pop_tx;
      end
      chk("R7 drained", tx_valid, 0);
    end

    // R9 user receive
    for (int n = 0; n < 3; n++) rx(n[1:0], 0, TW'(n), DW'(8'h40 + n));
    chk("R9 in_empty", in_empty, 3'b000);
    chk("R9 no irq", irq, 0);
    for (int n = 0; n < 3; n++) begin
      usr_net = n[1:0];
      #0;
      chk("R9 head", {usr_tag, usr_data}, {TW'(n), DW'(8'h40 + n)});
      pop_usr;
    end
    chk("R9 read out", in_empty, 3'b111);

    // R13 read of empty queue
    usr_net = 1;
    pop_usr;
    sys_rd = 1; tick; sys_rd = 0;
    rx(1, 0, 2, 8'h5A);
    chk("R13 usr after empty read", {in_empty, usr_tag, usr_data}, {3'b101, 2'd2, 8'h5A});
    pop_usr;
    chk("R13 sys unaffected", sys_empty, 1);

    // R11 inbound overflow
    usr_net = 0;
    for (int i = 0; i < DEPTH; i++) rx(0, 0, 1, DW'(8'h50 + i));
    chk("R5 in_full bit", in_full, 3'b001);
    rx(0, 0, 1, 8'hFF);
    chk("R11 rx_ovf user", rx_ovf, 1);
    for (int i = 0; i < DEPTH; i++) begin
      chk("R11 kept", usr_data, DW'(8'h50 + i));
      pop_usr;
    end
    chk("R11 emptied", in_empty, 3'b111);
    clr;

    // R10 system receive and interrupt
    rx(2, 1, 1, 8'h77);
    chk("R10 irq raised", irq, 1);
    rx(0, 1, 2, 8'h66);
    chk("R10 head", {sys_net, sys_tag, sys_data}, {2'd2, 2'd1, 8'h77});
    chk("R10 no user entry", in_empty, 3'b111);
    pop_sys;
    chk("R10 irq held", irq, 1);
    chk("R10 second", {sys_net, sys_tag, sys_data}, {2'd0, 2'd2, 8'h66});
    pop_sys;
    chk("R10 irq dropped", {irq, sys_empty}, 2'b01);

    // R11 system queue overflow
    for (int i = 0; i < SDEPTH; i++) rx(1, 1, 0, DW'(8'h80 + i));
    chk("R11 sys_full", sys_full, 1);
    rx(1, 1, 0, 8'hFE);
    chk("R11 rx_ovf sys", rx_ovf, 1);
    for (int i = 0; i < SDEPTH; i++) begin
      chk("R11 sys kept", sys_data, DW'(8'h80 + i));
      pop_sys;
    end
    chk("R11 sys drained", irq, 0);

    // R12 clear versus set
    err_clr = 1;
    snd(0, 0, 1, 0, 8'h01);
    err_clr = 0;
    chk("R12 set wins", {prot_err, rx_ovf}, 2'b10);
    clr;
    chk("R12 cleared", {prot_err, snd_ovf, rx_ovf}, 0);

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule